// File: doc/BRIEF.md
# Channel Output Guard with Thermal, Supply and Link Supervision

This block sits between the committed channel command word and the gate enables of a bank of high-side switches. It decides whether each commanded channel may actually be driven. It also produces one active-low diagnostic flag for the control side. Sensors enter as digital values: one temperature code per channel, a supply voltage code for the output-side rail, and a supply-stable level. The isolated transfer link delivers one pulse per frame, marking the frame as either accepted or rejected.

Each channel has its own thermal latch, which trips and releases with hysteresis. A tripped channel is forced off without affecting its neighbours. An undervoltage latch on the output rail, also with hysteresis, forces every channel off. A counter of consecutive rejected frames blanks every channel once it reaches its limit, and the blanking lasts until an accepted frame arrives. The diagnostic flag goes low on any thermal trip or on undervoltage. Link blanking does not drive the flag.

Top module: `chan_guard`

## Requirements
- R1: While reset is asserted, every gate enable is 0 and the diagnostic flag `diag_no` is 1.
- R2: When no protection is active, the supply is stable and the link is healthy, `gate_o` equals the value of `cmd_i` sampled at the previous clock edge. Bit k drives channel k.
- R3: Channel k trips when its 8-bit code (bits 8k+7:8k of `temp_i`, unsigned, in °C) is strictly greater than 135. A code of exactly 135 does not trip. Once tripped, only gate bit k is forced to 0.
- R4: A tripped channel stays off while its code is 125 to 135 inclusive. It restarts, if still commanded, once its code is below 125.
- R5: `diag_no` is 0 whenever at least one channel is tripped, and it returns to 1 when none is.
- R6: The undervoltage latch sets when `vsup_i` (unsigned volts) is below 7 and clears only when `vsup_i` is 11 or more. While it is set, all gates are 0 and `diag_no` is 0.
- R7: Four consecutive rejected frames (`link_bad_i` pulses with no accepted frame between them) force all gates to 0. Three rejected frames do not. Link blanking alone leaves `diag_no` at 1.
- R8: An accepted frame (`link_ok_i`) clears the rejection count and ends blanking. If an accepted and a rejected pulse arrive in the same cycle, the accepted pulse wins.
- R9: While `stable_i` is 0, all gates are 0. The gates follow `cmd_i` again one edge after `stable_i` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 8 | Committed channel command word |
| temp_i | input | 64 | Per-channel temperature codes, channel k in bits 8k+7:8k |
| vsup_i | input | 8 | Output-side supply voltage code in volts |
| stable_i | input | 1 | Input side reports a stable state |
| link_ok_i | input | 1 | Pulse: transfer frame accepted |
| link_bad_i | input | 1 | Pulse: transfer frame rejected |
| gate_o | output | 8 | Per-channel gate enables |
| diag_no | output | 1 | Common diagnostic, low on overtemperature or undervoltage |

## Verification
Link recovery and thermal release can fall in the same cycle. The bench blanks the outputs with four rejected frames while one channel is tripped. It then sends an accepted frame while that channel is still hot, and the gates must return with only that channel held off. Only after that does the channel cool and rejoin. The bench also sends an accepted and a rejected pulse in the same cycle and checks that the accepted one wins. The bench exercises each hysteresis boundary value (135/136, 125/124, 7/6, 10/11) directly.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int unsigned CH_N       = 8;
  localparam int unsigned TEMP_W     = 8;
  localparam int unsigned VSUP_W     = 8;
  localparam int unsigned TRIP_C     = 135;
  localparam int unsigned HYST_K     = 10;
  localparam int unsigned UV_TRIP_V  = 7;
  localparam int unsigned UV_REST_V  = 11;
  localparam int unsigned REJ_LIMIT  = 4;
endpackage

// File: rtl/thermal_chan.sv
module thermal_chan #(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned TRIP_C = 135,
  parameter int unsigned HYST_K = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o
);
  localparam logic [TEMP_W-1:0] TripLvl = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] RelLvl  = TEMP_W'(TRIP_C - HYST_K);

  logic hot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hot_q <= 1'b0;
    else if (temp_i > TripLvl) hot_q <= 1'b1;
    else if (temp_i < RelLvl)  hot_q <= 1'b0;
  end

  assign hot_o = hot_q;

  // R3
  hot_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i > TripLvl) |=> hot_q);
  // R4
  hot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_q && temp_i >= RelLvl) |=> hot_q);
  // R4
  cool_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i < RelLvl) |=> !hot_q);
endmodule

// File: rtl/supply_mon.sv
module supply_mon #(
  parameter int unsigned VSUP_W    = 8,
  parameter int unsigned UV_TRIP_V = 7,
  parameter int unsigned UV_REST_V = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VSUP_W-1:0] vsup_i,
  output logic              uv_o
);
  localparam logic [VSUP_W-1:0] LoLvl = VSUP_W'(UV_TRIP_V);
  localparam logic [VSUP_W-1:0] HiLvl = VSUP_W'(UV_REST_V);

  logic uv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             uv_q <= 1'b0;
    else if (vsup_i < LoLvl)  uv_q <= 1'b1;
    else if (vsup_i >= HiLvl) uv_q <= 1'b0;
  end

  assign uv_o = uv_q;

  // R6
  uv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_q && vsup_i < HiLvl) |=> uv_q);
  // R6
  uv_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsup_i < LoLvl) |=> uv_q);
endmodule

// File: rtl/link_watch.sv
module link_watch #(
  parameter int unsigned REJ_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,
  input  logic bad_i,
  output logic fail_o
);
  localparam int unsigned CntW = $clog2(REJ_LIMIT + 1);
  localparam logic [CntW-1:0] Lim = CntW'(REJ_LIMIT);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (ok_i)                 cnt_q <= '0;
    else if (bad_i && cnt_q != Lim) cnt_q <= cnt_q + 1'b1;
  end

  assign fail_o = (cnt_q == Lim);

  // R8
  accept_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_i |=> !fail_o);
  // R7
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !ok_i) |=> fail_o);
  // R7
  reach_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == Lim - 1'b1 && bad_i && !ok_i) |=> fail_o);
endmodule

// File: rtl/chan_guard.sv
module chan_guard
  import guard_pkg::*;
#(
  parameter int unsigned N      = CH_N,
  parameter int unsigned TW     = TEMP_W,
  parameter int unsigned VW     = VSUP_W,
  parameter int unsigned TRIP   = TRIP_C,
  parameter int unsigned HYST   = HYST_K,
  parameter int unsigned UV_LO  = UV_TRIP_V,
  parameter int unsigned UV_HI  = UV_REST_V,
  parameter int unsigned REJ_N  = REJ_LIMIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  cmd_i,
  input  logic [N*TW-1:0] temp_i,
  input  logic [VW-1:0] vsup_i,
  input  logic          stable_i,
  input  logic          link_ok_i,
  input  logic          link_bad_i,
  output logic [N-1:0]  gate_o,
  output logic          diag_no
);
  logic [N-1:0] hot;
  logic         uv;
  logic         link_fail;
  logic         allow;
  logic [N-1:0] gate_q;

  for (genvar k = 0; k < N; k++) begin : g_ch
    thermal_chan #(
      .TEMP_W(TW),
      .TRIP_C(TRIP),
      .HYST_K(HYST)
    ) u_th (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .temp_i(temp_i[k*TW +: TW]),
      .hot_o (hot[k])
    );
  end

  supply_mon #(
    .VSUP_W   (VW),
    .UV_TRIP_V(UV_LO),
    .UV_REST_V(UV_HI)
  ) u_sup (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vsup_i(vsup_i),
    .uv_o  (uv)
  );

  link_watch #(
    .REJ_LIMIT(REJ_N)
  ) u_link (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ok_i  (link_ok_i),
    .bad_i (link_bad_i),
    .fail_o(link_fail)
  );

  assign allow = stable_i & ~uv & ~link_fail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else         gate_q <= cmd_i & ~hot & {N{allow}};
  end

  assign gate_o  = gate_q;
  assign diag_no = ~((|hot) | uv);

  // R9
  unstable_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stable_i |=> (gate_o == '0));
  // R7
  blank_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_fail |=> (gate_o == '0));
  // R6
  uv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv |=> (gate_o == '0));
  // R2
  no_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((gate_o & ~$past(cmd_i)) == '0));
endmodule

// File: tb/chan_guard_tb.sv
module chan_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cmd = '0;
  logic [7:0]  t [8];
  logic [63:0] temp_vec;
  logic [7:0]  vsup = 8'd24;
  logic        stable = 1'b0;
  logic        ok = 1'b0;
  logic        bad = 1'b0;
  logic [7:0]  gate;
  logic        diag_n;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < 8; i++) temp_vec[i*8 +: 8] = t[i];

  chan_guard u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cmd_i     (cmd),
    .temp_i    (temp_vec),
    .vsup_i    (vsup),
    .stable_i  (stable),
    .link_ok_i (ok),
    .link_bad_i(bad),
    .gate_o    (gate),
    .diag_no   (diag_n)
  );

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk_gate(string req, logic [7:0] exp);
    n_chk++;
    if (gate !== exp) begin
      n_fail++;
      $display("FAIL %s gate actual=%h expected=%h", req, gate, exp);
    end
  endtask

  task automatic chk_diag(string req, logic exp);
    n_chk++;
    if (diag_n !== exp) begin
      n_fail++;
      $display("FAIL %s diag actual=%b expected=%b", req, diag_n, exp);
    end
  endtask

  task automatic pulse_bad(int n);
    for (int i = 0; i < n; i++) begin bad = 1'b1; tick(); bad = 1'b0; end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) t[i] = 8'd40;
    cmd = 8'hFF; stable = 1'b1;
    tick(2);
    chk_gate("R1", 8'h00);
    chk_diag("R1", 1'b1);
    rst_n = 1'b1;
    cmd = 8'h00;
    tick();
  endtask

  task automatic t_pass;
    cmd = 8'hA5; tick();
    chk_gate("R2", 8'hA5);
    cmd = 8'h3C; tick();
    chk_gate("R2", 8'h3C);
    cmd = 8'hFF; tick();
    chk_gate("R2", 8'hFF);
  endtask

  task automatic t_thermal;
    t[2] = 8'd135; tick(2);
    chk_gate("R3", 8'hFF);
    chk_diag("R5", 1'b1);
    t[2] = 8'd136; tick(2);
    chk_gate("R3", 8'hFB);
    chk_diag("R5", 1'b0);
    t[2] = 8'd125; tick(2);
    chk_gate("R4", 8'hFB);
    t[2] = 8'd124; tick(2);
    chk_gate("R4", 8'hFF);
    chk_diag("R5", 1'b1);
    t[0] = 8'd200; t[7] = 8'd150; tick(2);
    chk_gate("R3", 8'h7E);
    t[0] = 8'd40; t[7] = 8'd40; tick(2);
    chk_gate("R4", 8'hFF);
  endtask

  task automatic t_uv;
    vsup = 8'd7; tick(2);
    chk_gate("R6", 8'hFF);
    vsup = 8'd6; tick(2);
    chk_gate("R6", 8'h00);
    chk_diag("R6", 1'b0);
    vsup = 8'd10; tick(2);
    chk_gate("R6", 8'h00);
    vsup = 8'd11; tick(2);
    chk_gate("R6", 8'hFF);
    chk_diag("R6", 1'b1);
  endtask

  task automatic t_link;
    pulse_bad(3); tick();
    chk_gate("R7", 8'hFF);
    pulse_bad(1); tick();
    chk_gate("R7", 8'h00);
    chk_diag("R7", 1'b1);
    ok = 1'b1; bad = 1'b1; tick(); ok = 1'b0; bad = 1'b0; tick();
    chk_gate("R8", 8'hFF);
    pulse_bad(2);
    ok = 1'b1; tick(); ok = 1'b0;
    pulse_bad(2); tick();
    chk_gate("R8", 8'hFF);
    pulse_bad(2); tick();
    chk_gate("R7", 8'h00);
    ok = 1'b1; tick(); ok = 1'b0; tick();
    chk_gate("R8", 8'hFF);
  endtask

  task automatic t_stable;
    stable = 1'b0; tick();
    chk_gate("R9", 8'h00);
    stable = 1'b1; tick();
    chk_gate("R9", 8'hFF);
  endtask

  task automatic t_combo;
    t[5] = 8'd140;
    pulse_bad(4); tick();
    chk_gate("R7", 8'h00);
    chk_diag("R5", 1'b0);
    ok = 1'b1; tick(); ok = 1'b0; tick();
    chk_gate("R8", 8'hDF);
    t[5] = 8'd100; tick(2);
    chk_gate("R4", 8'hFF);
    chk_diag("R5", 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pass();
    t_thermal();
    t_uv();
    t_link();
    t_stable();
    t_combo();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule